// File: doc/BRIEF.md
# Per-Stage Instruction Slice Gating Tracker

This block runs alongside a five-stage, single-issue integer pipeline (fetch, decode, execute, memory, writeback). It watches the fetched 32-bit instruction word for a configurable set of instruction classes, each identified by its 6-bit major opcode. When it sees a match, it launches a token for that class. The token then travels down a per-class chain of stage flags. It advances one stage per clock, and only when the receiving stage is not frozen.

For every stage, the block turns the flags into a vector of functional-unit enables. Each class carries a parameter mask of the units it really uses. A unit is disabled in a stage only while that stage holds a tracked instruction whose mask leaves the unit out. In every other case the enable stays high, so the gated pipeline computes exactly what the ungated one would. The opcodes, the masks, the number of classes and the number of units are all parameters.

The enables are meant to feed clock-gating or operand-isolation logic elsewhere. The block contains no gating cells and no datapath.

Top module: `slice_gate_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every class flag in every stage, which leaves all unit enables high.
- R2: At a rising edge, the fetch-stage flag of class c is loaded with 1 only under all of these conditions: `instr_word[31:26]` equals the opcode of class c, `rst` is low, `flush` is low and `freeze[0]` is low. In every other case it is loaded with 0. Class 0 defaults to opcode 6'b111000 (add with carry).
- R3: At a rising edge, the decode-stage flag of class c is loaded with the fetch-stage flag of class c as it stood before that edge, ANDed with "not `freeze[1]`" and "not `flush`".
- R4: At a rising edge, the execute, memory and writeback flags (stages 2, 3 and 4) of class c are each loaded with the previous stage's flag of class c as it stood before that edge, ANDed with "not `freeze[s]`". Here `freeze[s]` is the freeze bit of the receiving stage.
- R5: A high `flush` at a rising edge clears every class flag in the fetch and decode stages on that same edge.
- R6: At most one class flag is set in any stage at any time.
- R7: Unit enable `unit_en[s*NUM_UNITS+u]` is 0 only when some class c has its stage-s flag set and bit u of that class's mask (`CLS_MASKS[c*NUM_UNITS+u]`) is 0. In every other case it is 1, so no unit used by an in-flight tracked instruction is ever disabled.
- R8: The flag of class c in stage s is output on `stage_flags[s*NUM_CLS+c]`. Stages are numbered 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback. Each class has its own chain, which no other class affects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 32 | Instruction word presented at fetch |
| flush | input | 1 | Pipeline flush request |
| freeze | input | 5 | Per-stage freeze, bit s for stage s |
| stage_flags | output | 5*NUM_CLS | Class occupancy flags, stage-major |
| unit_en | output | 5*NUM_UNITS | Functional-unit enables, stage-major |

## Verification
The bench first sends a clean run of add-with-carry words through an unfrozen pipeline. This shows that tokens move exactly one stage per clock and that the enable pattern follows the token. Directed cases then freeze one downstream stage and assert flush while tokens sit in fetch and decode. These separate three behaviours: a frozen stage dropping the token, a flush clearing only the two front stages, and a later stage still receiving its predecessor. A long run of random words, taken from all tracked opcodes plus untracked ones, with random freeze and flush patterns, is checked cycle by cycle against a queued reference model of the flags. For every occupied stage the bench also checks that no unit in the class mask has been turned off.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int unsigned STAGES  = 5;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned OPC_LSB = 26;
  localparam int unsigned WORD_W  = 32;

  typedef enum logic [2:0] {
    STG_FETCH  = 3'd0,
    STG_DECODE = 3'd1,
    STG_EXEC   = 3'd2,
    STG_MEM    = 3'd3,
    STG_WB     = 3'd4
  } stage_e;

  // true when the major opcode field matches a class opcode
  function automatic logic opc_hit(input logic [OPC_W-1:0] field,
                                   input logic [OPC_W-1:0] opc);
    return field == opc;
  endfunction

  // a stage kills its incoming token when frozen, and the front two also on flush
  function automatic logic stage_kill(input int unsigned stg,
                                      input logic frz, input logic fl);
    return frz | (fl & (stg <= 32'(STG_DECODE)));
  endfunction
endpackage

// File: rtl/slt_fetch_match.sv
module slt_fetch_match
  import slt_pkg::*;
#(
  parameter int unsigned NUM_CLS = 4,
  parameter logic [NUM_CLS*OPC_W-1:0] CLS_OPCODES = '0
) (
  input  logic [OPC_W-1:0]   opc_field,
  output logic [NUM_CLS-1:0] hit_vec
);
  // priority pick: lowest class index wins, so the result is one-hot-or-zero
  always_comb begin
    logic taken;
    taken   = 1'b0;
    hit_vec = '0;
    for (int c = 0; c < int'(NUM_CLS); c++) begin
      if (!taken && opc_hit(opc_field, CLS_OPCODES[c*OPC_W +: OPC_W])) begin
        hit_vec[c] = 1'b1;
        taken      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/slt_stage_reg.sv
module slt_stage_reg #(
  parameter int unsigned NUM_CLS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CLS-1:0] prev_flags,
  input  logic               kill,
  output logic [NUM_CLS-1:0] flags_q
);
  logic [NUM_CLS-1:0] flags_d;
  logic               advance_ev;

  assign advance_ev = ~kill;
  assign flags_d    = advance_ev ? prev_flags : '0;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  AST_TOKEN_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (flags_q != '0) |-> (($past(prev_flags) == flags_q) && !$past(kill)));  // R4
  AST_STAGE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags_q));  // R6
endmodule

// File: rtl/slt_enable_gen.sv
module slt_enable_gen #(
  parameter int unsigned NUM_CLS   = 4,
  parameter int unsigned NUM_UNITS = 8,
  parameter logic [NUM_CLS*NUM_UNITS-1:0] CLS_MASKS = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CLS-1:0]   flags,
  output logic [NUM_UNITS-1:0] en
);
  logic [NUM_UNITS-1:0] used_mask;

  always_comb begin
    for (int u = 0; u < int'(NUM_UNITS); u++) begin
      logic off;
      off = 1'b0;
      for (int c = 0; c < int'(NUM_CLS); c++)
        off = off | (flags[c] & ~CLS_MASKS[c*NUM_UNITS+u]);
      en[u] = ~off;
    end
  end

  // mask of the resident class, used only by the checks below
  always_comb begin
    used_mask = '0;
    for (int c = 0; c < int'(NUM_CLS); c++)
      if (flags[c]) used_mask = used_mask | CLS_MASKS[c*NUM_UNITS +: NUM_UNITS];
  end

  AST_IDLE_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |-> (en == '1));  // R7
  AST_USED_NEVER_OFF: assert property (@(posedge clk) disable iff (rst)
    ((en & used_mask) == used_mask));  // R7
endmodule

// File: rtl/slice_gate_tracker.sv
module slice_gate_tracker
  import slt_pkg::*;
#(
  parameter int unsigned NUM_CLS   = 4,
  parameter int unsigned NUM_UNITS = 8,
  parameter logic [NUM_CLS*OPC_W-1:0] CLS_OPCODES =
    {6'b000100, 6'b100011, 6'b100001, 6'b111000},
  parameter logic [NUM_CLS*NUM_UNITS-1:0] CLS_MASKS =
    {8'hC1, 8'h2D, 8'h1B, 8'h07}
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WORD_W-1:0]           instr_word,
  input  logic                        flush,
  input  logic [STAGES-1:0]           freeze,
  output logic [STAGES*NUM_CLS-1:0]   stage_flags,
  output logic [STAGES*NUM_UNITS-1:0] unit_en
);
  logic [NUM_CLS-1:0] hit_vec;
  logic [NUM_CLS-1:0] flag_q   [STAGES];
  logic [NUM_CLS-1:0] flag_in  [STAGES];
  logic [STAGES-1:0]  kill_vec;
  logic               unused_low;

  assign unused_low = ^instr_word[OPC_LSB-1:0];

  slt_fetch_match #(.NUM_CLS(NUM_CLS), .CLS_OPCODES(CLS_OPCODES)) u_match (
    .opc_field (instr_word[WORD_W-1:OPC_LSB]),
    .hit_vec   (hit_vec)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_src
      assign flag_in[s] = hit_vec;
    end else begin : g_chain
      assign flag_in[s] = flag_q[s-1];
    end
    assign kill_vec[s] = stage_kill(s, freeze[s], flush);

    slt_stage_reg #(.NUM_CLS(NUM_CLS)) u_reg (
      .clk        (clk),
      .rst        (rst),
      .prev_flags (flag_in[s]),
      .kill       (kill_vec[s]),
      .flags_q    (flag_q[s])
    );

    slt_enable_gen #(.NUM_CLS(NUM_CLS), .NUM_UNITS(NUM_UNITS),
                     .CLS_MASKS(CLS_MASKS)) u_en (
      .clk   (clk),
      .rst   (rst),
      .flags (flag_q[s]),
      .en    (unit_en[s*NUM_UNITS +: NUM_UNITS])
    );

    assign stage_flags[s*NUM_CLS +: NUM_CLS] = flag_q[s];
  end

  AST_FLUSH_FRONT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> ((flag_q[0] == '0) && (flag_q[1] == '0)));  // R5
  AST_FETCH_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    (flag_q[0] != '0) |-> ($past(hit_vec) == flag_q[0] && !$past(freeze[0])));  // R2
  AST_DECODE_FROM_FETCH: assert property (@(posedge clk) disable iff (rst)
    (flag_q[1] != '0) |-> ($past(flag_q[0]) == flag_q[1] && !$past(freeze[1])));  // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (stage_flags == '0));  // R1
endmodule

// File: tb/slice_gate_tracker_test.sv
module slice_gate_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NU = 8;
  localparam int NS = 5;
  localparam logic [NC*6-1:0]  OPCS  = {6'b000100, 6'b100011, 6'b100001, 6'b111000};
  localparam logic [NC*NU-1:0] MASKS = {8'hC1, 8'h2D, 8'h1B, 8'h07};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] instr_word = '0;
  logic flush = 1'b0;
  logic [NS-1:0] freeze = '0;
  logic [NS*NC-1:0] stage_flags;
  logic [NS*NU-1:0] unit_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NS*NC-1:0] fl;
    logic [NS*NU-1:0] en;
    int cls [NS];
    bit was_rst;
    bit was_flush;
  } exp_t;

  exp_t exp_q [$];
  int mdl [NS] = '{-1, -1, -1, -1, -1};

  always #(CLK_PERIOD/2) clk = ~clk;

  slice_gate_tracker #(.NUM_CLS(NC), .NUM_UNITS(NU), .CLS_OPCODES(OPCS),
                       .CLS_MASKS(MASKS)) uut (
    .clk(clk), .rst(rst), .instr_word(instr_word), .flush(flush),
    .freeze(freeze), .stage_flags(stage_flags), .unit_en(unit_en)
  );

  function automatic int class_of(logic [5:0] opc);
    for (int c = 0; c < NC; c++) if (OPCS[c*6 +: 6] == opc) return c;
    return -1;
  endfunction

  // drive one cycle at the falling edge and queue what must appear after the next rising edge
  task automatic drive(input logic r, input logic [31:0] w, input logic f,
                       input logic [NS-1:0] fz);
    exp_t e;
    int nx [NS];
    @(negedge clk);
    rst = r; instr_word = w; flush = f; freeze = fz;
    nx[0] = (r || f || fz[0]) ? -1 : class_of(w[31:26]);   // R2
    nx[1] = (r || f || fz[1]) ? -1 : mdl[0];               // R3 R5
    for (int s = 2; s < NS; s++) nx[s] = (r || fz[s]) ? -1 : mdl[s-1];  // R4
    e.fl = '0; e.en = '1;
    for (int s = 0; s < NS; s++) begin
      mdl[s] = nx[s];
      e.cls[s] = nx[s];
      if (nx[s] >= 0) begin
        e.fl[s*NC + nx[s]] = 1'b1;
        e.en[s*NU +: NU] = MASKS[nx[s]*NU +: NU];
      end
    end
    e.was_rst = r; e.was_flush = f;
    exp_q.push_back(e);
  endtask

  function automatic string flag_tag(int s, exp_t e);
    if (e.was_rst) return "R1";
    if (s <= 1 && e.was_flush) return "R5";
    if (s == 0) return "R2";
    if (s == 1) return "R3";
    return "R4";
  endfunction

  // monitor: compare a quarter period after every rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      for (int s = 0; s < NS; s++) begin
        logic [NC-1:0] af;
        logic [NU-1:0] ae;
        af = stage_flags[s*NC +: NC];
        ae = unit_en[s*NU +: NU];
        checks++;
        if (af !== e.fl[s*NC +: NC]) begin
          errors++;
          $display("FAIL %s R8 stage %0d flags actual %b expected %b", flag_tag(s, e), s, af, e.fl[s*NC +: NC]);
        end
        checks++;
        if (ae !== e.en[s*NU +: NU]) begin
          errors++;
          $display("FAIL %s R7 stage %0d enables actual %b expected %b", e.was_rst ? "R1" : "", s, ae, e.en[s*NU +: NU]);
        end
        checks++;
        if ($countones(af) > 1) begin
          errors++;
          $display("FAIL R6 stage %0d flags actual %b expected at most one set", s, af);
        end
        if (e.cls[s] >= 0) begin
          logic [NU-1:0] m;
          m = MASKS[e.cls[s]*NU +: NU];
          checks++;
          if ((ae & m) !== m) begin
            errors++;
            $display("FAIL R7 stage %0d used unit disabled actual %b expected mask %b covered", s, ae, m);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [31:0] W_ADDC = {6'b111000, 26'h0000123};
  localparam logic [31:0] W_C1   = {6'b100001, 26'h0abcdef};
  localparam logic [31:0] W_OTH  = {6'b010101, 26'h1234567};

  initial begin
    // R1: reset cycles, all flags zero, all enables high
    repeat (3) drive(1'b1, W_ADDC, 1'b0, '0);
    // R2 R3 R4: clean add-with-carry flow through all stages
    drive(1'b0, W_ADDC, 1'b0, '0);
    repeat (6) drive(1'b0, W_OTH, 1'b0, '0);
    // R8: two classes back to back, independent chains
    drive(1'b0, W_C1, 1'b0, '0);
    drive(1'b0, W_ADDC, 1'b0, '0);
    repeat (6) drive(1'b0, W_OTH, 1'b0, '0);
    // R4: execute frozen when token should arrive
    drive(1'b0, W_ADDC, 1'b0, '0);
    drive(1'b0, W_OTH, 1'b0, '0);
    drive(1'b0, W_OTH, 1'b0, 5'b00100);
    repeat (4) drive(1'b0, W_OTH, 1'b0, '0);
    // R2: fetch frozen blocks the match
    drive(1'b0, W_ADDC, 1'b0, 5'b00001);
    drive(1'b0, W_OTH, 1'b0, '0);
    // R5: flush with tokens in fetch and decode; execute keeps its token
    drive(1'b0, W_ADDC, 1'b0, '0);
    drive(1'b0, W_C1, 1'b0, '0);
    drive(1'b0, W_ADDC, 1'b1, '0);
    repeat (5) drive(1'b0, W_OTH, 1'b0, '0);
    // R1: reset in mid flight
    drive(1'b0, W_ADDC, 1'b0, '0);
    drive(1'b0, W_C1, 1'b0, '0);
    drive(1'b1, W_OTH, 1'b0, '0);
    drive(1'b0, W_OTH, 1'b0, '0);
    // random streams
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      logic [NS-1:0] fz;
      int pick;
      w = $urandom;
      pick = $urandom_range(0, 5);
      if (pick < NC) w[31:26] = OPCS[pick*6 +: 6];
      fz = '0;
      for (int s = 0; s < NS; s++) fz[s] = ($urandom_range(0, 7) == 0);
      drive(1'b0, w, ($urandom_range(0, 15) == 0), fz);
    end
    drive(1'b0, W_OTH, 1'b0, '0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule